// File: doc/BRIEF.md
# Randomized Dual-Modulus Clock Divider

This block divides its input clock by an integer `n` or by `n+1`, choosing afresh for every output period. At the start of each period it draws a new pseudorandom word from an internal maximal-length LFSR and compares it with a programmable fractional word `K`. If the word is smaller than `K`, that period is one input clock longer. Over many periods the mean period is `n + K/2^N` input clocks. Because the long and short periods are chosen at random rather than by a carry chain, the modulus sequence has no repeating pattern. Its energy then spreads as white frequency jitter instead of falling into discrete spurs.

It is intended as the clock-generation stage of a fractional-rate source. A consumer uses the one-cycle `out_pulse` as its enable or tick. The `long_period` flag tells downstream logic which modulus the current period used, for example to correct a phase estimate.

Top module: `rand_dual_mod_div`

## Requirements
- R1: While `rst_n` is low, `out_pulse` and `long_period` are 0. The first clock cycle after `rst_n` rises is the first cycle of a new period.
- R2: A period lasts `n+1` input clocks when the random word is less than `K`, and `n` input clocks otherwise. `out_pulse` is high for exactly one input clock, on the last cycle of the period.
- R3: The random word is the low `FRAC_W` bits of a right-shifting Galois LFSR of width `2*FRAC_W`. At each step the LFSR shifts right by one and, if the bit shifted out was 1, is XORed with the feedback mask (`16'hB400` for a 16-bit register). Reset loads `SEED`. The first period uses the seed's low bits, and the LFSR advances exactly once per period, after its word has been used.
- R4: When `out_pulse` is high, `long_period` is 1 if that period lasted `n+1` clocks and 0 if it lasted `n` clocks.
- R5: `div_n` and `frac_k` are sampled only in the first cycle of a period. A change during the later cycles of a period has no effect on that period's length and applies from the next period onward.
- R6: With `frac_k` = 0, every period lasts `n` clocks and `long_period` is 0 at every pulse.
- R7: A `div_n` value of 0 or 1 is treated as 2.
- R8: Over many periods, the fraction of long periods tends to `K/2^FRAC_W`, so the mean output frequency is `fc/(n + K/2^FRAC_W)`.
- R9: The LFSR state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| div_n | input | DIV_W | Integer divide value n (values below 2 act as 2) |
| frac_k | input | FRAC_W | Fractional word K; probability of a long period is K/2^FRAC_W |
| out_pulse | output | 1 | One-clock pulse on the last cycle of each divided period |
| long_period | output | 1 | 1 when the current period uses n+1 |

## Verification
The bench builds the divider with `DIV_W` = 6, `FRAC_W` = 8 and a 16-bit LFSR. With 8 bits, both extremes of `K` are easy to drive: 0, which forces every period short, and 255, where nearly every word is below `K`. A 16-bit LFSR with a fixed seed is also small enough for the bench to predict every random word. The bench therefore checks each period's exact length and flag against its own model. It does this across clamped divide values, changes of `n` and `K` in the middle of a period, a reset in the middle of a period, and a run of 512 periods used for the long-run ratio.

// File: rtl/rdm_pkg.sv
// Package: shared helpers for the randomized dual-modulus divider.
// Assumes LFSR widths from the supported set; any other width falls back
// to the 16-bit feedback mask and is not maximal length.
package rdm_pkg;

    // Returns the right-shift Galois feedback mask of a maximal-length LFSR.
    function automatic logic [63:0] galois_mask(input int unsigned width);
        case (width)
            8:       return 64'h0000_00B8;
            10:      return 64'h0000_0240;
            12:      return 64'h0000_0E08;
            16:      return 64'h0000_B400;
            20:      return 64'h0009_0000;
            24:      return 64'h00E1_0000;
            32:      return 64'h8020_0003;
            default: return 64'h0000_B400;
        endcase
    endfunction

endpackage

// File: rtl/rdm_lfsr.sv
// Module: rdm_lfsr
// Right-shifting Galois LFSR that advances by one state when step is high.
// Assumes SEED is nonzero; reset is synchronous and active low.
module rdm_lfsr #(
    parameter int unsigned W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    import rdm_pkg::*;

    localparam logic [63:0]  MASK_ALL = galois_mask(W);
    localparam logic [W-1:0] MASK     = MASK_ALL[W-1:0];

    logic [W-1:0] state_q;
    logic [W-1:0] state_nx;

    // Compute the next state: shift right, fold in taps on an outgoing 1.
    always_comb begin
        state_nx = state_q >> 1;
        if (state_q[0]) state_nx = state_nx ^ MASK;
    end

    // Hold the register, load the seed on reset, step once per request.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= SEED;
        else if (step) state_q <= state_nx;
    end

    assign state = state_q;

    // R9
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R3
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

endmodule

// File: rtl/rdm_modsel.sv
// Module: rdm_modsel
// Chooses the modulus for each period. At a period start it clamps n to at
// least 2, compares the random word against K and latches the index of the
// period's last cycle together with the long-period flag.
// Assumes start is high only in the first cycle of a period.
module rdm_modsel #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned FRAC_W = 8,
    parameter int unsigned CNT_W  = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_n,
    input  logic [FRAC_W-1:0] frac_k,
    input  logic [FRAC_W-1:0] rand_word,
    output logic [CNT_W-1:0]  last_idx,
    output logic              long_sel
);
    logic [DIV_W-1:0] n_eff;
    logic             pick_long;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] last_q;
    logic             long_q;

    // Clamp the integer divide value to the smallest legal modulus.
    always_comb begin
        n_eff = (div_n < DIV_W'(2)) ? DIV_W'(2) : div_n;
    end

    // Random compare: a word below K lengthens the period by one clock.
    always_comb begin
        pick_long = (rand_word < frac_k);
        len       = CNT_W'(n_eff) + CNT_W'(pick_long);
    end

    // Latch the decision once per period so mid-period input changes wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            long_q <= 1'b0;
        end else if (start) begin
            last_q <= len - CNT_W'(1);
            long_q <= pick_long;
        end
    end

    assign last_idx = last_q;
    assign long_sel = long_q;

    // R5
    sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(last_q) && $stable(long_q)));

    // R7
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (last_q >= CNT_W'(1)));

    // R6
    k_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && frac_k == '0) |=> !long_q);

endmodule

// File: rtl/rdm_period_ctr.sv
// Module: rdm_period_ctr
// Counts input clocks inside a period. Flags the first cycle (count 0) as
// the period start and pulses on the cycle whose count equals last_idx.
// Assumes last_idx is at least 1 whenever the count is nonzero.
module rdm_period_ctr #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] last_idx,
    output logic             start,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt_q;

    // Decode the first and last cycle of the running period.
    always_comb begin
        start = (cnt_q == '0);
        pulse = (cnt_q != '0) && (cnt_q == last_idx);
    end

    // Advance the count, wrapping to zero after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (pulse) cnt_q <= '0;
        else            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!pulse && start));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q <= last_idx));

endmodule

// File: rtl/rand_dual_mod_div.sv
// Module: rand_dual_mod_div (top)
// Divides clk by n or n+1 per output period. The choice is made by comparing
// a fresh LFSR word against K, which gives an average period of n+K/2^N.
// Assumes a free-running clk and a synchronous active-low reset.
module rand_dual_mod_div #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned FRAC_W = 8,
    parameter int unsigned LFSR_W = 2 * FRAC_W,
    parameter logic [LFSR_W-1:0] SEED = LFSR_W'(16'hACE1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_n,
    input  logic [FRAC_W-1:0] frac_k,
    output logic              out_pulse,
    output logic              long_period
);
    localparam int unsigned CNT_W = DIV_W + 1;

    logic              start;
    logic              pulse;
    logic [LFSR_W-1:0] lfsr_state;
    logic [CNT_W-1:0]  last_idx;
    logic              long_sel;

    rdm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_idx (last_idx),
        .start    (start),
        .pulse    (pulse)
    );

    rdm_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (start),
        .state (lfsr_state)
    );

    rdm_modsel #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .div_n     (div_n),
        .frac_k    (frac_k),
        .rand_word (lfsr_state[FRAC_W-1:0]),
        .last_idx  (last_idx),
        .long_sel  (long_sel)
    );

    assign out_pulse   = pulse;
    assign long_period = long_sel;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_pulse && !long_period));

endmodule

// File: tb/test_rand_dual_mod_div.sv
`timescale 1ns/1ps
module test_rand_dual_mod_div;
    localparam int DIV_W  = 6;
    localparam int FRAC_W = 8;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam logic [15:0] MASK = 16'hB400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0]  n_drv = 6'd4;
    logic [FRAC_W-1:0] k_drv = 8'd0;
    logic out_pulse, long_period;

    int total = 0;
    int bad = 0;
    logic [15:0] mlfsr = SEED;
    int long_cnt;

    always #2 clk = ~clk;

    rand_dual_mod_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .LFSR_W(16), .SEED(SEED)) i_rand_dual_mod_div (
        .clk(clk), .rst_n(rst_n), .div_n(n_drv), .frac_k(k_drv),
        .out_pulse(out_pulse), .long_period(long_period)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        logic [15:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ MASK;
        return r;
    endfunction

    // Checks one whole period starting at the negedge of its first cycle.
    task automatic run_period(input string req, input int chg_at,
                              input logic [DIV_W-1:0] nn, input logic [FRAC_W-1:0] nk,
                              output logic was_long);
        int neff;
        int len;
        logic lng;
        logic ok;
        int act_len;
        neff = (n_drv < 2) ? 2 : int'(n_drv);
        lng  = (mlfsr[7:0] < k_drv);
        len  = neff + (lng ? 1 : 0);
        mlfsr = lfsr_next(mlfsr);
        ok = (out_pulse === 1'b0);
        act_len = 0;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (i == chg_at) begin n_drv = nn; k_drv = nk; end
            if (out_pulse !== (i == len - 1)) begin
                ok = 1'b0;
                if (act_len == 0 && out_pulse === 1'b1) act_len = i + 1;
            end
            if (i == len - 1 && long_period !== lng) ok = 1'b0;
        end
        @(negedge clk);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: period act_len=%0d (0=no early pulse) exp_len=%0d act_flag=%b exp_flag=%b",
                     req, act_len, len, long_period, lng);
        end
        was_long = lng;
    endtask

    // Holds reset for a few cycles, checks outputs stay low, then releases.
    task automatic apply_reset(input string req);
        logic ok;
        ok = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (out_pulse !== 1'b0 || long_period !== 1'b0) ok = 1'b0;
        end
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: during reset pulse=%b flag=%b exp 0/0", req, out_pulse, long_period);
        end
        mlfsr = SEED;
        rst_n = 1'b1;
    endtask

    task automatic test_reset_and_seed();
        logic l;
        apply_reset("R1");
        // R3: first periods follow the seed's word sequence
        for (int p = 0; p < 8; p++) run_period("R3", 0, '0, '0, l);
    endtask

    task automatic test_basic_mix();
        logic l;
        n_drv = 6'd5; k_drv = 8'd100;
        // R2, R4: mixed lengths under a mid-range K
        for (int p = 0; p < 40; p++) run_period("R2", 0, '0, '0, l);
        n_drv = 6'd9; k_drv = 8'd200;
        for (int p = 0; p < 40; p++) run_period("R4", 0, '0, '0, l);
    endtask

    task automatic test_k_extremes();
        logic l;
        int longs;
        n_drv = 6'd3; k_drv = 8'd0;
        longs = 0;
        // R6: K=0 never lengthens
        for (int p = 0; p < 30; p++) begin
            run_period("R6", 0, '0, '0, l);
            if (l) longs++;
        end
        total++;
        if (longs != 0) begin
            bad++;
            $display("FAIL R6: long periods act=%0d exp=0", longs);
        end
        k_drv = 8'd255;
        for (int p = 0; p < 30; p++) run_period("R2", 0, '0, '0, l);
    endtask

    task automatic test_clamp();
        logic l;
        k_drv = 8'd128;
        n_drv = 6'd0;
        // R7: n of 0 and 1 act as 2
        for (int p = 0; p < 12; p++) run_period("R7", 0, '0, '0, l);
        n_drv = 6'd1;
        for (int p = 0; p < 12; p++) run_period("R7", 0, '0, '0, l);
        n_drv = 6'd2;
        for (int p = 0; p < 12; p++) run_period("R7", 0, '0, '0, l);
    endtask

    task automatic test_midperiod_change();
        logic l;
        n_drv = 6'd8; k_drv = 8'd0;
        // R5: change in cycle 1 applies only from the next period
        run_period("R5", 1, 6'd3, 8'd255, l);
        run_period("R5", 2, 6'd12, 8'd0, l);
        run_period("R5", 3, 6'd6, 8'd90, l);
        for (int p = 0; p < 6; p++) run_period("R5", 0, '0, '0, l);
    endtask

    task automatic test_midperiod_reset();
        logic l;
        n_drv = 6'd20; k_drv = 8'd50;
        run_period("R1", 0, '0, '0, l);
        repeat (5) @(negedge clk);
        apply_reset("R1");
        // R1, R3: after a reset mid-period the seed sequence restarts
        for (int p = 0; p < 6; p++) run_period("R1", 0, '0, '0, l);
    endtask

    task automatic test_long_run();
        logic l;
        n_drv = 6'd4; k_drv = 8'd64;
        long_cnt = 0;
        // R8: fraction of long periods close to 64/256
        for (int p = 0; p < 512; p++) begin
            run_period("R8", 0, '0, '0, l);
            if (l) long_cnt++;
        end
        total++;
        if (long_cnt < 88 || long_cnt > 168) begin
            bad++;
            $display("FAIL R8: long count act=%0d exp=88..168 (~128)", long_cnt);
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: run act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset_and_seed();
        test_basic_mix();
        test_k_extremes();
        test_clamp();
        test_midperiod_change();
        test_midperiod_reset();
        test_long_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule